// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block sequences page programming for a byte-wide memory of 512 locations split into aligned pages of 8 bytes. A host stages bytes with load requests into an 8-slot page buffer, then issues a start request. If a guarded write-enable latch allows it, the controller enters a self-timed programming interval whose length is a cycle-count parameter. When that interval ends, the staged bytes are copied into the array. The array is a register file inside the block, and any address can be read combinationally at all times.

The latch is clear after reset. It is armed only by a rearm request, and it is dropped when a commit finishes or whenever the active-low protect input is low. A ready bit is 0 while a write is in flight and 1 otherwise. The controller has three states:

- IDLE: accepts rearm, load and start requests.
- PROG: the timed interval.
- COMMIT: a single cycle that writes the page.

The transitions are:

- IDLE->PROG on an accepted start.
- PROG->COMMIT when the timer expires.
- COMMIT->IDLE unconditionally.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, ready_o is 1 and every array location reads 8'hFF. The latch is clear, so a start with bytes loaded but no prior rearm is ignored.
- R2: A rearm in IDLE with wp_n_i high arms the latch and discards all staged bytes. A rearm takes priority over a load or start in the same cycle, and both of those are dropped.
- R3: The first load into an empty buffer fixes the page as address bits [8:3] and the slot as bits [2:0]. Each later load ignores its address and goes to the next slot, wrapping from slot 7 to slot 0 in the same page. A slot loaded twice keeps the last byte.
- R4: A start is accepted only in IDLE with the latch armed, wp_n_i high and at least one slot loaded. Otherwise it has no effect: ready_o stays 1 and the array is unchanged.
- R5: ready_o is 0 for exactly PROG_CYCLES+1 cycles, counted from the clock edge that samples an accepted start, and then returns to 1.
- R6: A commit writes only the loaded slots. The other bytes of the page, and all other pages, keep their contents.
- R7: While ready_o is 0 the array still returns its old contents. New data is readable from the first cycle ready_o is 1 again.
- R8: The latch clears when a commit completes, so a second start without a fresh rearm is ignored.
- R9: wp_n_i low clears the latch. A later start is ignored, even after wp_n_i returns high, until the next rearm.
- R10: wp_n_i going low during PROG does not abort or delay the write in flight.
- R11: Rearm, load and start requests while ready_o is 0 are ignored. The write in flight commits its original bytes on time, and the buffer is empty afterwards.
- R12: A rearm while wp_n_i is low does not arm the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Write protect, active low |
| rearm_i | input | 1 | Rearm request: arms latch, empties buffer |
| load_i | input | 1 | Load-byte request |
| load_addr_i | input | 9 | Byte address for a load |
| load_data_i | input | 8 | Byte to stage |
| start_i | input | 1 | Start-programming request |
| rd_addr_i | input | 9 | Array read address |
| rd_data_o | output | 8 | Array read data (combinational) |
| ready_o | output | 1 | 1 when idle, 0 while a write is in flight |

## Verification
Requests take effect at the clock edge that samples them. ready_o therefore drops in the cycle after a start pulse and rises again PROG_CYCLES+1 edges later, at the same moment the page contents change. The bench drives requests on the falling edge. It samples ready_o one falling edge after the start pulse, again PROG_CYCLES edges later (still 0), and once more on the following falling edge (1, with new data). Reads are combinational, so array sweeps settle the address and compare within the same idle interval.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROG   = 2'd1,
        ST_COMMIT = 2'd2
    } pwc_state_e;
endpackage

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic                                   clr,
    input  logic [ADDR_W-1:0]                      addr,
    input  logic [DATA_W-1:0]                      data,
    output logic [ADDR_W-PAGE_W-1:0]               base_o,
    output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]     slot_data_o,
    output logic [(1<<PAGE_W)-1:0]                 valid_o,
    output logic                                   any_valid_o
);
    localparam int SLOTS  = 1 << PAGE_W;
    localparam int BASE_W = ADDR_W - PAGE_W;

    logic [SLOTS-1:0]  valid_q;
    logic [PAGE_W-1:0] ptr_q;
    logic [BASE_W-1:0] base_q;
    logic              empty;
    logic [PAGE_W-1:0] slot;

    assign empty = ~|valid_q;
    assign slot  = empty ? addr[PAGE_W-1:0] : ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
            base_q  <= '0;
        end else if (clr) begin
            valid_q <= '0;
        end else if (wr_en) begin
            if (empty) begin
                base_q <= addr[ADDR_W-1:PAGE_W];
            end
            valid_q[slot] <= 1'b1;
            ptr_q         <= slot + 1'b1;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_en && !clr && (slot == PAGE_W'(g))) begin
                byte_q <= data;
            end
        end
        assign slot_data_o[g] = byte_q;
    end

    assign base_o      = base_q;
    assign valid_o     = valid_q;
    assign any_valid_o = ~empty;
endmodule

// File: rtl/pwc_timer.sv
module pwc_timer #(
    parameter int PROG_CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done_o
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(PROG_CYCLES - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = run && (cnt_q == '0);
endmodule

// File: rtl/pwc_array.sv
module pwc_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               commit,
    input  logic [ADDR_W-PAGE_W-1:0]           base,
    input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0] slot_data,
    input  logic [(1<<PAGE_W)-1:0]             valid,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [DATA_W-1:0]                  rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (commit) begin
            for (int s = 0; s < (1 << PAGE_W); s++) begin
                if (valid[s]) begin
                    mem_q[{base, PAGE_W'(s)}] <= slot_data[s];
                end
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr];
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
    import pwc_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 3,
    parameter int PROG_CYCLES = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_i,
    input  logic              rearm_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ready_o
);
    localparam int SLOTS  = 1 << PAGE_W;
    localparam int BASE_W = ADDR_W - PAGE_W;

    pwc_state_e state_q, state_d;
    logic       wel_q;
    logic       idle, prog_run, commit, start_ok, tmr_done;
    logic       buf_wr, buf_clr, any_valid;
    logic [BASE_W-1:0]             base;
    logic [SLOTS-1:0][DATA_W-1:0]  slot_data;
    logic [SLOTS-1:0]              valid;

    // start qualifier: latch armed, protect released, something staged
    assign start_ok = start_i && !rearm_i && wel_q && wp_n_i && any_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok) state_d = ST_PROG;
            ST_PROG:   if (tmr_done) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        idle     = 1'b0;
        prog_run = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_IDLE:   idle     = 1'b1;
            ST_PROG:   prog_run = 1'b1;
            ST_COMMIT: commit   = 1'b1;
            default:   idle     = 1'b1;
        endcase
    end

    assign ready_o = idle;

    // write-enable latch: protect dominates, commit clears, rearm arms
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
        end else if (!wp_n_i || commit) begin
            wel_q <= 1'b0;
        end else if (idle && rearm_i) begin
            wel_q <= 1'b1;
        end
    end

    assign buf_wr  = idle && load_i && !rearm_i && !start_i;
    assign buf_clr = (idle && rearm_i) || commit;

    pwc_page_buf #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (buf_wr),
        .clr         (buf_clr),
        .addr        (load_addr_i),
        .data        (load_data_i),
        .base_o      (base),
        .slot_data_o (slot_data),
        .valid_o     (valid),
        .any_valid_o (any_valid)
    );

    pwc_timer #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (idle && start_ok),
        .run    (prog_run),
        .done_o (tmr_done)
    );

    pwc_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .base      (base),
        .slot_data (slot_data),
        .valid     (valid),
        .rd_addr   (rd_addr_i),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker
    import pwc_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 2000000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n_i,
    input logic              rearm_i,
    input logic              start_i,
    input logic              ready_o,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              wel,
    input pwc_state_e        state,
    input logic              any_valid
);
    int unsigned low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= 0;
        end else if (!ready_o) begin
            low_cnt <= low_cnt + 1;
        end else begin
            low_cnt <= 0;
        end
    end

    assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (low_cnt == PROG_CYCLES + 1));

    assert_start_nolatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i && !wel) |=> ready_o);

    assert_start_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i && !any_valid) |=> ready_o);

    assert_rearm_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && rearm_i && wp_n_i) |=> wel);

    assert_latch_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> !wel);

    assert_protect_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n_i |=> !wel);

    assert_rearm_protected_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm_i && !wp_n_i) |=> !wel);

    assert_no_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && !wp_n_i) |=> (state != ST_IDLE));

    assert_old_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && $stable(rd_addr_i)) |-> $stable(rd_data_o));
endmodule

bind page_write_ctrl pwc_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_n_i    (wp_n_i),
    .rearm_i   (rearm_i),
    .start_i   (start_i),
    .ready_o   (ready_o),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .wel       (wel_q),
    .state     (state_q),
    .any_valid (any_valid)
);

// File: tb/page_write_ctrl_tb.sv
`timescale 1ns/1ps
module page_write_ctrl_tb;
    localparam int P = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_n_i = 1'b1;
    logic       rearm_i = 1'b0;
    logic       load_i = 1'b0;
    logic [8:0] load_addr_i = '0;
    logic [7:0] load_data_i = '0;
    logic       start_i = 1'b0;
    logic [8:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       ready_o;

    always #2.5 clk = ~clk;

    page_write_ctrl #(.PROG_CYCLES(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n_i), .rearm_i(rearm_i),
        .load_i(load_i), .load_addr_i(load_addr_i), .load_data_i(load_data_i),
        .start_i(start_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .ready_o(ready_o)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // reference model built from the requirements
    logic [7:0] m_mem [512];
    logic       m_wel;
    logic [7:0] m_valid;
    logic [7:0] m_data [8];
    logic [5:0] m_base;
    logic [2:0] m_ptr;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_accept();
        return m_wel && wp_n_i && (m_valid != 8'h00);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic sweep(input string tag);
        int bad = 0;
        int first_act = 0;
        int first_exp = 0;
        for (int a = 0; a < 512; a++) begin
            rd_addr_i = 9'(a);
            #0.01;
            if (rd_data_o !== m_mem[a]) begin
                if (bad == 0) begin
                    first_act = {a, rd_data_o};
                    first_exp = {a, m_mem[a]};
                end
                bad++;
            end
        end
        chk(bad == 0, tag, first_act, first_exp);
    endtask

    task automatic rearm();
        rearm_i = 1'b1;
        tick();
        rearm_i = 1'b0;
        m_valid = '0;
        if (wp_n_i) m_wel = 1'b1;
    endtask

    task automatic load(input logic [8:0] a, input logic [7:0] d);
        logic [2:0] s;
        load_i = 1'b1;
        load_addr_i = a;
        load_data_i = d;
        tick();
        load_i = 1'b0;
        if (m_valid == 0) begin
            m_base = a[8:3];
            s = a[2:0];
        end else begin
            s = m_ptr;
        end
        m_data[s] = d;
        m_valid[s] = 1'b1;
        m_ptr = s + 3'd1;
    endtask

    task automatic protect_pulse();
        wp_n_i = 1'b0;
        tick();
        wp_n_i = 1'b1;
        m_wel = 1'b0;
    endtask

    // issue a start; the model decides whether it must be taken
    task automatic start(input string tag, input bit disturb);
        bit acc;
        logic [8:0] probe;
        acc = exp_accept();
        probe = 9'(0);
        for (int s = 0; s < 8; s++) if (m_valid[s]) probe = {m_base, 3'(s)};
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        if (!acc) begin
            chk(ready_o == 1'b1, {tag, " R4 start ignored"}, ready_o, 1);
            sweep({tag, " R4 array unchanged"});
            return;
        end
        chk(ready_o == 1'b0, {tag, " R5 busy after start"}, ready_o, 0);
        for (int k = 0; k < P; k++) begin
            if (k == 1) begin
                rd_addr_i = probe;
                #0.01;
                chk(rd_data_o == m_mem[probe], {tag, " R7 old data while busy"},
                    rd_data_o, m_mem[probe]);
            end
            if (disturb) begin
                if (k == 2) begin wp_n_i = 1'b0; rearm_i = 1'b1; end
                if (k == 3) begin wp_n_i = 1'b1; rearm_i = 1'b0; load_i = 1'b1;
                                  load_addr_i = probe; load_data_i = ~m_data[probe[2:0]]; end
                if (k == 4) begin load_i = 1'b0; start_i = 1'b1; end
                if (k == 5) start_i = 1'b0;
            end
            tick();
        end
        chk(ready_o == 1'b0, {tag, " R5 still busy at last cycle"}, ready_o, 0);
        tick();
        chk(ready_o == 1'b1, {tag, " R5 ready after interval"}, ready_o, 1);
        for (int s = 0; s < 8; s++) if (m_valid[s]) m_mem[{m_base, 3'(s)}] = m_data[s];
        m_valid = '0;
        m_wel = 1'b0;
        sweep({tag, " R6 R7 array after commit"});
    endtask

    initial begin
        for (int a = 0; a < 512; a++) m_mem[a] = 8'hFF;
        m_wel = 0; m_valid = '0; m_base = '0; m_ptr = '0;
        void'($urandom(32'h5EED));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk(ready_o == 1'b1, "R1 ready after reset", ready_o, 1);
        sweep("R1 erased array");
        load(9'h021, 8'hA5);
        start("R1 no rearm", 0);
        // R2 R3: wrap inside page starting at slot 5 of page 1
        rearm();
        load(9'h00D, 8'h11); load(9'h1F0, 8'h22); load(9'h000, 8'h33);
        load(9'h0AA, 8'h44); load(9'h055, 8'h55);
        start("R3 wrap", 0);
        // R8: no second write without rearm
        load(9'h040, 8'h66);
        start("R8 latch cleared", 0);
        // R9: protect pulse drops latch
        rearm(); load(9'h048, 8'h77); protect_pulse();
        start("R9 protect cleared latch", 0);
        // R12: rearm under protect does not arm
        wp_n_i = 1'b0; rearm(); wp_n_i = 1'b1;
        load(9'h050, 8'h88);
        start("R12 rearm while protected", 0);
        // R4: armed but nothing loaded; protect low at start
        rearm();
        start("R4 empty buffer", 0);
        load(9'h058, 8'h99);
        wp_n_i = 1'b0; m_wel = 1'b0;
        start("R4 protect at start", 0);
        wp_n_i = 1'b1;
        // R3: ten loads overwrite the first two slots
        rearm();
        for (int i = 0; i < 10; i++) load(9'h100 + 9'(i), 8'(8'hC0 + i));
        start("R3 overwrite", 0);
        // R2: rearm discards staged bytes
        load(9'h180, 8'hDE); rearm(); load(9'h18B, 8'hAD);
        start("R2 rearm discards", 0);
        // R10 R11: disturbances during busy
        rearm(); load(9'h1C2, 8'h5A); load(9'h1C3, 8'hA5);
        start("R10 R11 disturbed write", 1);
        rearm(); load(9'h013, 8'h3C);
        start("R11 buffer empty after commit", 0);
        // random mix
        for (int it = 0; it < 40; it++) begin
            int n;
            if ($urandom_range(0, 3) != 0) rearm();
            n = $urandom_range(0, 12);
            for (int j = 0; j < n; j++) load(9'($urandom_range(0, 511)), 8'($urandom));
            if ($urandom_range(0, 5) == 0) protect_pulse();
            start("R6 random", 0);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R5 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule